// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

A multi-cycle integer arithmetic unit that multiplies or divides two 32-bit operands on a single shift-and-add/subtract datapath. One wide adder serves both operations. Multiply runs as right-shifting shift-and-add. Divide runs as left-shifting restoring division. Signed operations work on operand magnitudes, and a sign correction is applied to the final value.

A client pulses `start_i` with an operation code and two operands. It then waits for `done_o`. The 64-bit result is read from two 32-bit words, `hi_o` and `lo_o`. A multiply leaves the upper product word in `hi_o` and the lower word in `lo_o`. A divide leaves the remainder in `hi_o` and the quotient in `lo_o`. There is no trap for a zero divisor or for division overflow; both finish in normal time with a defined value. After a multiply, `ovf_o` reports that the product does not fit in one 32-bit word.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_i` = 2'b01 (unsigned multiply), the completed result satisfies {`hi_o`,`lo_o`} = `opa_i` × `opb_i` as a 64-bit unsigned product.
- R2: With `op_i` = 2'b00 (signed multiply), {`hi_o`,`lo_o`} is the 64-bit two's-complement product of the operands read as signed values.
- R3: With `op_i` = 2'b11 (unsigned divide) and a nonzero divisor, `lo_o` is the quotient `opa_i`/`opb_i` and `hi_o` is the remainder.
- R4: With `op_i` = 2'b10 (signed divide) and a nonzero divisor, the quotient is truncated toward zero and is negative exactly when the operand signs differ. The remainder has the sign of the dividend. Dividing the most negative value by -1 gives quotient 32'h8000_0000 and remainder 0.
- R5: A zero divisor, signed or unsigned, completes in the normal time with `lo_o` = 32'hFFFF_FFFF and `hi_o` equal to the dividend.
- R6: `busy_o` rises in the cycle after `start_i` is accepted and stays high for exactly 32 cycles. `done_o` is high for exactly one cycle, which is the first cycle after `busy_o` falls. The new result is visible on `hi_o`/`lo_o`/`ovf_o` in that cycle.
- R7: `start_i` asserted while `busy_o` is high is ignored. The running operation's result and timing are unchanged, and no second operation follows it.
- R8: After a multiply completes, `ovf_o` is 1 exactly when the product cannot be represented in 32 bits. For unsigned multiply this means `hi_o` ≠ 0. For signed multiply it means `hi_o` is not 32 copies of `lo_o` bit 31. After a divide completes, `ovf_o` is 0.
- R9: `hi_o`, `lo_o` and `ovf_o` keep their previous values from one completion to the next, including throughout an operation in progress.
- R10: While `rst_ni` is low, `busy_o`, `done_o`, `hi_o`, `lo_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa_i | input | 32 | Multiplicand / dividend |
| opb_i | input | 32 | Multiplier / divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper product word or remainder |
| lo_o | output | 32 | Lower product word or quotient |
| ovf_o | output | 1 | Product exceeds 32 bits |

## Verification
The bench builds the unit with its default width of 32. At this width the most negative operand, the all-ones unsigned product and the exact boundary where a signed product reaches 2^31 can all be driven directly as corner vectors. It also makes the 32-cycle iteration count observable as a precise busy window. Zero-divisor cases for both signednesses, a start pulse issued mid-operation, and probes of the result words during a running operation cover the remaining behaviour.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } op_e;
endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] a_mag_o,
  output logic [WIDTH-1:0] b_mag_o,
  output logic             is_div_o,
  output logic             is_signed_o,
  output logic             neg_main_o,
  output logic             neg_rem_o,
  output logic             zero_div_o
);
  op_e  op;
  logic sa, sb;

  always_comb begin
    op          = op_e'(op_i);
    is_div_o    = (op == OP_DIV) || (op == OP_DIVU);
    is_signed_o = (op == OP_MUL) || (op == OP_DIV);
    sa          = is_signed_o & opa_i[WIDTH-1];
    sb          = is_signed_o & opb_i[WIDTH-1];
    a_mag_o     = sa ? -opa_i : opa_i;
    b_mag_o     = sb ? -opb_i : opb_i;
    neg_main_o  = sa ^ sb;
    neg_rem_o   = sa;
    zero_div_o  = (opb_i == '0);
  end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int AW = WIDTH + 2;

  logic [WIDTH:0]  shl;
  logic [AW-1:0]   add_a, add_b, sum;
  logic            cin, qbit;

  // one adder: add for multiply, subtract for divide
  always_comb begin
    shl = {hi_i, lo_i[WIDTH-1]};
    if (is_div_i) begin
      add_a = {1'b0, shl};
      add_b = ~{2'b00, b_i};
      cin   = 1'b1;
    end else begin
      add_a = {2'b00, hi_i};
      add_b = lo_i[0] ? {2'b00, b_i} : '0;
      cin   = 1'b0;
    end
    sum  = add_a + add_b + {{(AW-1){1'b0}}, cin};
    qbit = ~sum[AW-1];
    if (is_div_i) begin
      hi_o = qbit ? sum[WIDTH-1:0] : shl[WIDTH-1:0];  // restore on negative
      lo_o = {lo_i[WIDTH-2:0], qbit};
    end else begin
      hi_o = sum[WIDTH:1];
      lo_o = {sum[0], lo_i[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_fixup.sv
module muldiv_fixup #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic             is_signed_i,
  input  logic             neg_main_i,
  input  logic             neg_rem_i,
  input  logic             zero_div_i,
  input  logic [WIDTH-1:0] hi_i,
  input  logic [WIDTH-1:0] lo_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             ovf_o
);
  logic [2*WIDTH-1:0] prod;

  always_comb begin
    prod  = {hi_i, lo_i};
    hi_o  = hi_i;
    lo_o  = lo_i;
    ovf_o = 1'b0;
    if (is_div_i) begin
      // zero divisor keeps the all-ones quotient untouched
      if (neg_main_i && !zero_div_i) lo_o = -lo_i;
      if (neg_rem_i)                 hi_o = -hi_i;
    end else begin
      if (neg_main_i) prod = -prod;
      hi_o = prod[2*WIDTH-1:WIDTH];
      lo_o = prod[WIDTH-1:0];
      if (is_signed_i) ovf_o = (hi_o != {WIDTH{lo_o[WIDTH-1]}});
      else             ovf_o = (hi_o != '0);
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             ovf_o
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] a_mag, b_mag;
  logic             p_div, p_signed, p_neg_main, p_neg_rem, p_zero;

  logic [WIDTH-1:0] acc_hi_q, acc_lo_q, b_q;
  logic [WIDTH-1:0] nx_hi, nx_lo, fx_hi, fx_lo;
  logic             fx_ovf;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, done_q, div_q, signed_q, neg_main_q, neg_rem_q, zero_q;
  logic [WIDTH-1:0] res_hi_q, res_lo_q;
  logic             ovf_q;
  logic             accept;

  muldiv_prep #(.WIDTH(WIDTH)) i_prep (
    .op_i        (op_i),
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .a_mag_o     (a_mag),
    .b_mag_o     (b_mag),
    .is_div_o    (p_div),
    .is_signed_o (p_signed),
    .neg_main_o  (p_neg_main),
    .neg_rem_o   (p_neg_rem),
    .zero_div_o  (p_zero)
  );

  muldiv_step #(.WIDTH(WIDTH)) i_step (
    .is_div_i (div_q),
    .hi_i     (acc_hi_q),
    .lo_i     (acc_lo_q),
    .b_i      (b_q),
    .hi_o     (nx_hi),
    .lo_o     (nx_lo)
  );

  muldiv_fixup #(.WIDTH(WIDTH)) i_fixup (
    .is_div_i    (div_q),
    .is_signed_i (signed_q),
    .neg_main_i  (neg_main_q),
    .neg_rem_i   (neg_rem_q),
    .zero_div_i  (zero_q),
    .hi_i        (nx_hi),
    .lo_i        (nx_lo),
    .hi_o        (fx_hi),
    .lo_o        (fx_lo),
    .ovf_o       (fx_ovf)
  );

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_hi_q   <= '0;
      acc_lo_q   <= '0;
      b_q        <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      div_q      <= 1'b0;
      signed_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      zero_q     <= 1'b0;
      res_hi_q   <= '0;
      res_lo_q   <= '0;
      ovf_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        acc_hi_q   <= '0;
        acc_lo_q   <= a_mag;
        b_q        <= b_mag;
        cnt_q      <= '0;
        busy_q     <= 1'b1;
        div_q      <= p_div;
        signed_q   <= p_signed;
        neg_main_q <= p_neg_main;
        neg_rem_q  <= p_neg_rem;
        zero_q     <= p_zero;
      end else if (busy_q) begin
        acc_hi_q <= nx_hi;
        acc_lo_q <= nx_lo;
        cnt_q    <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          res_hi_q <= fx_hi;
          res_lo_q <= fx_lo;
          ovf_q    <= fx_ovf;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = res_hi_q;
  assign lo_o   = res_lo_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o,
  input logic             ovf_o
);
  localparam int BW = $clog2(WIDTH + 1) + 1;

  logic [BW-1:0]    bcnt;
  logic             cap_div, cap_mulu, cap_zero;
  logic [WIDTH-1:0] cap_a;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt     <= '0;
      cap_div  <= 1'b0;
      cap_mulu <= 1'b0;
      cap_zero <= 1'b0;
      cap_a    <= '0;
    end else begin
      bcnt <= busy_o ? bcnt + 1'b1 : '0;
      if (start_i && !busy_o) begin
        cap_div  <= op_i[1];
        cap_mulu <= (op_i == 2'b01);
        cap_zero <= (opb_i == '0);
        cap_a    <= opa_i;
      end
    end
  end

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bcnt == BW'(WIDTH)));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(hi_o) && $stable(lo_o) && $stable(ovf_o)));
  p_div_no_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_div) |-> !ovf_o);
  p_mulu_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_mulu) |-> (ovf_o == (hi_o != '0)));
  p_zero_div_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_div && cap_zero) |-> ((lo_o == '1) && (hi_o == cap_a)));
endmodule

bind muldiv_unit muldiv_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] hi;
    logic [31:0] lo;
    logic        ovf;
  } vec_t;

  localparam int NV = 17;
  // R1 unsigned mul, R2 signed mul, R3 unsigned div, R4 signed div, R5 zero divisor, R8 ovf
  localparam vec_t VECS [NV] = '{
    '{2'b01, 32'd3,          32'd5,          32'h0,          32'd15,         1'b0},
    '{2'b01, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'hFFFFFFFE,   32'h00000001,   1'b1},
    '{2'b01, 32'h00010000,   32'h00010000,   32'h00000001,   32'h0,          1'b1},
    '{2'b00, 32'hFFFFFFFD,   32'd5,          32'hFFFFFFFF,   32'hFFFFFFF1,   1'b0},
    '{2'b00, 32'hFFFFFFFF,   32'hFFFFFFFF,   32'h0,          32'h1,          1'b0},
    '{2'b00, 32'h80000000,   32'h80000000,   32'h40000000,   32'h0,          1'b1},
    '{2'b00, 32'h80000000,   32'h1,          32'hFFFFFFFF,   32'h80000000,   1'b0},
    '{2'b00, 32'h00010000,   32'h00008000,   32'h0,          32'h80000000,   1'b1},
    '{2'b11, 32'd100,        32'd7,          32'd2,          32'd14,         1'b0},
    '{2'b11, 32'hFFFFFFFF,   32'd2,          32'd1,          32'h7FFFFFFF,   1'b0},
    '{2'b11, 32'd3,          32'd10,         32'd3,          32'd0,          1'b0},
    '{2'b10, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF,   32'hFFFFFFFD,   1'b0},
    '{2'b10, 32'd7,          32'hFFFFFFFE,   32'd1,          32'hFFFFFFFD,   1'b0},
    '{2'b10, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'hFFFFFFFF,   32'd3,          1'b0},
    '{2'b10, 32'h80000000,   32'hFFFFFFFF,   32'h0,          32'h80000000,   1'b0},
    '{2'b11, 32'd5,          32'd0,          32'd5,          32'hFFFFFFFF,   1'b0},
    '{2'b10, 32'hFFFFFFF9,   32'd0,          32'hFFFFFFF9,   32'hFFFFFFFF,   1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done, ovf;
  logic [31:0] hi, lo;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .opa_i(opa), .opb_i(opb), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo), .ovf_o(ovf)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 done", 64'(done), 64'd0);
    check("R10 hi/lo", {hi, lo}, 64'd0);
    check("R10 ovf", 64'(ovf), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      kick(VECS[i].op, VECS[i].a, VECS[i].b);
      wait_idle(n);
      check($sformatf("R6 busy cycles v%0d", i), 64'(n), 64'd32);
      check($sformatf("R6 done v%0d", i), 64'(done), 64'd1);
      check($sformatf("R1-4 result v%0d op%0b", i, VECS[i].op), {hi, lo}, {VECS[i].hi, VECS[i].lo});
      check($sformatf("R8 ovf v%0d", i), 64'(ovf), 64'(VECS[i].ovf));
      @(negedge clk);
      check($sformatf("R6 done pulse v%0d", i), 64'(done), 64'd0);
    end

    // R7: start mid-operation is ignored
    kick(2'b01, 32'd3, 32'd5);
    repeat (9) @(negedge clk);
    start = 1'b1; op = 2'b11; opa = 32'd100; opb = 32'd0;
    @(negedge clk);
    start = 1'b0;
    wait_idle(n);
    check("R7 busy cycles", 64'(n + 10), 64'd32);
    check("R7 result", {hi, lo}, {32'h0, 32'd15});
    repeat (3) @(negedge clk);
    check("R7 no follow-on op", 64'(busy), 64'd0);
    check("R7 result held", {hi, lo}, {32'h0, 32'd15});

    // R9: results hold during a running operation
    kick(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF);
    repeat (5) @(negedge clk);
    check("R9 busy mid-op", 64'(busy), 64'd1);
    check("R9 hi/lo held", {hi, lo}, {32'h0, 32'd15});
    check("R9 ovf held", 64'(ovf), 64'd0);
    wait_idle(n);
    check("R9 new result", {hi, lo}, {32'hFFFFFFFE, 32'h1});
    check("R8 ovf after mulu", 64'(ovf), 64'd1);

    // R8: a following divide clears ovf
    kick(2'b11, 32'd9, 32'd3);
    wait_idle(n);
    check("R8 ovf after div", 64'(ovf), 64'd0);
    check("R3 9/3", {hi, lo}, {32'd0, 32'd3});

    // R10: reset mid-operation
    kick(2'b00, 32'd7, 32'd7);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset busy", 64'(busy), 64'd0);
    check("R10 reset hi/lo", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule